// File: doc/BRIEF.md
# I2C Master Bit Engine with Clock Stretching and Arbitration

This block is the bit-level engine of an I2C master. A controller above it asks for one bus action at a time (a Start, a repeated Start, a Stop, one transmitted bit or one received bit) through a valid/ready command handshake, and gets a one-cycle response when the action is complete. The engine drives both bus lines as open-drain: an output-enable that pulls the line low when high, and a synchronized sample of the wired line coming back.

SCL timing comes from a reloadable down-counter. Each phase the master times lasts `baud_div + 1` cycles. When the master releases SCL it stops the counter until the synchronized SCL is actually high, then reloads it. A device that holds the clock low therefore stretches the low phase, and the high phase still gets its full length. While a transmitted '1' is on the bus, the engine compares the line with its own bit at the end of the high phase. A '0' there means another master has won. The engine then lets go of both lines, returns to idle, and raises a sticky event flag. That flag blocks new commands until it is cleared.

`baud_div` must be at least `SYNC_STAGES`, so that the synchronized SCL has followed the master's own low drive before the release is judged.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `scl_oe`, `sda_oe`, `rsp_valid` and `evt_collision` are all 0.
- R2: `cmd_code` values are: 0 Start, 1 repeated Start, 2 Stop, 3 write bit, 4 read bit. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` stays 0 until the action ends, and the end is marked by a one-cycle `rsp_valid` pulse.
- R3: For a write, read, Stop or repeated Start, SCL is driven low for `baud_div + 1` cycles from the cycle after the command is taken.
- R4: If SCL is not stretched, the master keeps SCL released for `baud_div + SYNC_STAGES + 2` rising edges. The count starts at the first rising edge that sees SCL high on the bus.
- R5: If another device holds SCL low after the master releases it, the counter waits. The high phase measured as in R4 keeps the same length, whatever the stretch lasts.
- R6: A Start taken while the bus is idle pulls SDA low while SCL is released. It holds that state for `baud_div + 1` cycles, then pulls SCL low, and completes with both lines driven low.
- R7: A Stop drives SDA low before releasing SCL. After the high phase it releases SDA while SCL is high, and leaves both lines released.
- R8: A repeated Start releases SDA before releasing SCL. While SCL is high it pulls SDA low, holds that for `baud_div + 1` cycles, and completes with both lines driven low.
- R9: A write bit drives `sda_oe` as the inverse of `cmd_wdata` for the whole bit. `sda_oe` does not change while SCL is released, so a write makes no Start or Stop edge. The bit completes with SCL driven low.
- R10: A read bit releases SDA. `rsp_rdata` returns the SDA level sampled at the end of the high phase.
- R11: If a write bit with `cmd_wdata` 1 samples SDA low at the end of its high phase, the engine releases both lines and returns to idle with no `rsp_valid`. `evt_collision` is set in the same cycle.
- R12: While `evt_collision` is 1, `cmd_ready` is 0 and commands have no effect on the lines. A one-cycle `evt_clear` clears the flag, and `cmd_ready` returns on the next cycle.
- R13: `cmd_code` values 5 to 7 are never taken. The lines, `cmd_ready` and `rsp_valid` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | BRG_W | Phase reload value; each timed phase is baud_div + 1 cycles |
| cmd_valid | input | 1 | Command request |
| cmd_code | input | 3 | Action code (see R2) |
| cmd_wdata | input | 1 | Bit to transmit for a write bit |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 1 | Bit received by the last read bit |
| scl_in | input | 1 | Level of the wired SCL line |
| scl_oe | output | 1 | High pulls SCL low |
| sda_in | input | 1 | Level of the wired SDA line |
| sda_oe | output | 1 | High pulls SDA low |
| evt_clear | input | 1 | One-cycle clear of the event flag |
| evt_collision | output | 1 | Sticky bus-collision event flag |

## Verification
The engine is run against a wired-AND bus model. Each bit is tried in four ways: with no other driver, with a slave driving SDA on reads, with a slave holding SCL low for a few cycles, and with a second master pulling SDA low halfway through a byte. Unstretched bits set the base phase lengths. Stretched bits must give the same high count, which shows that the counter froze and then reloaded. A read of a slave-driven '0' shows the sample point. A collision bit shows the abort path, because it differs from a good write only in the missing response and the released lines. The Start, Stop and repeated Start runs also record the order of the line edges, which separates real Start and Stop conditions from data changes.

// File: rtl/i2cbe_pkg.sv
`timescale 1ns/1ps
package i2cbe_pkg;

   typedef enum logic [2:0] {
      CMD_START   = 3'd0,
      CMD_RESTART = 3'd1,
      CMD_STOP    = 3'd2,
      CMD_WRITE   = 3'd3,
      CMD_READ    = 3'd4
   } cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_LOW,
      ST_RISE,
      ST_HIGH
   } phase_e;

   function automatic logic code_known(input logic [2:0] code);
      return code <= 3'd4;
   endfunction

endpackage

// File: rtl/i2cbe_sync.sv
`timescale 1ns/1ps
module i2cbe_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES > 4) begin : g_bad_depth
      $error("i2cbe_sync: STAGES must be 0 to 4");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q <= {STAGES{RST_VAL}};
         end else begin
            sh_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
               sh_q[i] <= sh_q[i-1];
            end
         end
      end
      assign q = sh_q[STAGES-1];
   end

endmodule

// File: rtl/i2cbe_baud.sv
`timescale 1ns/1ps
module i2cbe_baud #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] reload_val,
   input  logic         load,
   input  logic         run,
   output logic         tick
);

   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   if (W < 2 || W > 16) begin : g_bad_width
      $error("i2cbe_baud: W must be 2 to 16");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= reload_val;
      end else if (run) begin
         cnt_q <= (cnt_q == '0) ? reload_val : cnt_q - ONE;
      end
   end

   assign tick = run && (cnt_q == '0);

   AST_LOAD_NO_EARLY_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (load && reload_val != '0) |=> !tick); // R3

endmodule

// File: rtl/i2cbe_seq.sv
`timescale 1ns/1ps
module i2cbe_seq
   import i2cbe_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [2:0] cmd_code,
   input  logic       cmd_wdata,
   output logic       cmd_ready,
   output logic       rsp_valid,
   output logic       rsp_rdata,
   input  logic       scl_s,
   input  logic       sda_s,
   input  logic       tick,
   input  logic       evt_clear,
   output logic       evt_flag,
   output logic       scl_oe,
   output logic       sda_oe,
   output logic       cnt_load,
   output logic       cnt_run
);

   phase_e st_q;
   cmd_e   op_q;
   logic   wbit_q, scl_oe_q, sda_oe_q, rsp_q, rdata_q, evt_q;
   logic   accept, collide;

   assign cmd_ready = (st_q == ST_IDLE) && !evt_q;
   assign accept    = cmd_ready && cmd_valid && code_known(cmd_code);
   assign collide   = (st_q == ST_HIGH) && tick && (op_q == CMD_WRITE) && wbit_q && !sda_s;

   assign cnt_run  = (st_q == ST_START) || (st_q == ST_LOW) || (st_q == ST_HIGH);
   assign cnt_load = accept
                   || ((st_q == ST_RISE) && scl_s)
                   || ((st_q == ST_HIGH) && tick && (op_q == CMD_RESTART));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         op_q     <= CMD_START;
         wbit_q   <= 1'b0;
         scl_oe_q <= 1'b0;
         sda_oe_q <= 1'b0;
         rsp_q    <= 1'b0;
         rdata_q  <= 1'b0;
         evt_q    <= 1'b0;
      end else begin
         rsp_q <= 1'b0;
         if (evt_clear) evt_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  op_q   <= cmd_e'(cmd_code);
                  wbit_q <= cmd_wdata;
                  case (cmd_e'(cmd_code))
                     CMD_START: begin
                        sda_oe_q <= 1'b1;
                        st_q     <= ST_START;
                     end
                     CMD_RESTART: begin
                        scl_oe_q <= 1'b1;
                        sda_oe_q <= 1'b0;
                        st_q     <= ST_LOW;
                     end
                     CMD_STOP: begin
                        scl_oe_q <= 1'b1;
                        sda_oe_q <= 1'b1;
                        st_q     <= ST_LOW;
                     end
                     CMD_WRITE: begin
                        scl_oe_q <= 1'b1;
                        sda_oe_q <= !cmd_wdata;
                        st_q     <= ST_LOW;
                     end
                     default: begin
                        scl_oe_q <= 1'b1;
                        sda_oe_q <= 1'b0;
                        st_q     <= ST_LOW;
                     end
                  endcase
               end
            end
            ST_START: begin
               if (tick) begin
                  scl_oe_q <= 1'b1;
                  rsp_q    <= 1'b1;
                  st_q     <= ST_IDLE;
               end
            end
            ST_LOW: begin
               if (tick) begin
                  scl_oe_q <= 1'b0;
                  st_q     <= ST_RISE;
               end
            end
            ST_RISE: begin
               if (scl_s) st_q <= ST_HIGH;
            end
            ST_HIGH: begin
               if (tick) begin
                  if (collide) begin
                     scl_oe_q <= 1'b0;
                     sda_oe_q <= 1'b0;
                     evt_q    <= 1'b1;
                     st_q     <= ST_IDLE;
                  end else begin
                     case (op_q)
                        CMD_STOP: begin
                           sda_oe_q <= 1'b0;
                           rsp_q    <= 1'b1;
                           st_q     <= ST_IDLE;
                        end
                        CMD_RESTART: begin
                           sda_oe_q <= 1'b1;
                           st_q     <= ST_START;
                        end
                        CMD_READ: begin
                           rdata_q  <= sda_s;
                           scl_oe_q <= 1'b1;
                           rsp_q    <= 1'b1;
                           st_q     <= ST_IDLE;
                        end
                        default: begin
                           scl_oe_q <= 1'b1;
                           rsp_q    <= 1'b1;
                           st_q     <= ST_IDLE;
                        end
                     endcase
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign scl_oe    = scl_oe_q;
   assign sda_oe    = sda_oe_q;
   assign rsp_valid = rsp_q;
   assign rsp_rdata = rdata_q;
   assign evt_flag  = evt_q;

   AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_q |=> !rsp_q); // R2
   AST_HIGH_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HIGH) |-> !scl_oe_q); // R4
   AST_STRETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RISE && !scl_s) |=> (st_q == ST_RISE && !scl_oe_q)); // R5
   AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HIGH && !tick && (op_q == CMD_WRITE || op_q == CMD_READ)) |=> $stable(sda_oe_q)); // R9
   AST_COLLIDE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_q) |-> (!scl_oe_q && !sda_oe_q && st_q == ST_IDLE && !rsp_q)); // R11
   AST_FLAG_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && evt_q) |=> (st_q == ST_IDLE)); // R12

endmodule

// File: rtl/i2c_bit_engine.sv
`timescale 1ns/1ps
module i2c_bit_engine #(
   parameter int BRG_W       = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BRG_W-1:0] baud_div,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_code,
   input  logic             cmd_wdata,
   output logic             cmd_ready,
   output logic             rsp_valid,
   output logic             rsp_rdata,
   input  logic             scl_in,
   output logic             scl_oe,
   input  logic             sda_in,
   output logic             sda_oe,
   input  logic             evt_clear,
   output logic             evt_collision
);

   localparam int NLINES = 2;
   localparam int L_SCL  = 0;
   localparam int L_SDA  = 1;

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("i2c_bit_engine: SYNC_STAGES must be 0 to 4");
   end

   logic [NLINES-1:0] line_raw, line_s;
   logic tick, cnt_load, cnt_run;

   assign line_raw[L_SCL] = scl_in;
   assign line_raw[L_SDA] = sda_in;

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      i2cbe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (line_raw[g]),
         .q     (line_s[g])
      );
   end

   i2cbe_baud #(.W(BRG_W)) u_baud (
      .clk        (clk),
      .rst_n      (rst_n),
      .reload_val (baud_div),
      .load       (cnt_load),
      .run        (cnt_run),
      .tick       (tick)
   );

   i2cbe_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .cmd_wdata (cmd_wdata),
      .cmd_ready (cmd_ready),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .scl_s     (line_s[L_SCL]),
      .sda_s     (line_s[L_SDA]),
      .tick      (tick),
      .evt_clear (evt_clear),
      .evt_flag  (evt_collision),
      .scl_oe    (scl_oe),
      .sda_oe    (sda_oe),
      .cnt_load  (cnt_load),
      .cnt_run   (cnt_run)
   );

endmodule

// File: tb/sim_i2c_bit_engine.sv
`timescale 1ns/1ps
module sim_i2c_bit_engine;

   localparam int BAUD = 5;
   localparam int SYNC = 2;
   localparam int LO_EXP = BAUD + 1;
   localparam int HI_EXP = BAUD + SYNC + 2;
   localparam int NV = 18;

   // vector: code[10:8] wd[7] other_low[6] stretch[5:2] exp_rd[1] exp_evt[0]
   localparam logic [10:0] VEC [0:NV-1] = '{
      {3'd3, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0},
      {3'd3, 1'b0, 1'b0, 4'd4, 1'b0, 1'b0},
      {3'd3, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0},
      {3'd3, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
      {3'd3, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
      {3'd3, 1'b1, 1'b0, 4'd8, 1'b0, 1'b0},
      {3'd3, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
      {3'd3, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0},
      {3'd4, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0},
      {3'd4, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0},
      {3'd4, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0},
      {3'd4, 1'b0, 1'b0, 4'd5, 1'b1, 1'b0},
      {3'd4, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0},
      {3'd4, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0},
      {3'd4, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0},
      {3'd4, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0},
      {3'd4, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0},
      {3'd3, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [8:0] baud_div = 9'(BAUD);
   logic cmd_valid = 1'b0, cmd_wdata = 1'b0, evt_clear = 1'b0;
   logic [2:0] cmd_code = 3'd0;
   logic cmd_ready, rsp_valid, rsp_rdata, scl_oe, sda_oe, evt_collision;
   logic scl_in, sda_in;
   logic slave_scl_hold = 1'b0, other_sda_low = 1'b0;

   always #2.5 clk = ~clk;

   assign scl_in = ~(scl_oe | slave_scl_hold);
   assign sda_in = ~(sda_oe | other_sda_low);

   i2c_bit_engine #(.BRG_W(9), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .baud_div(baud_div),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_wdata(cmd_wdata),
      .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .scl_in(scl_in), .scl_oe(scl_oe), .sda_in(sda_in), .sda_oe(sda_oe),
      .evt_clear(evt_clear), .evt_collision(evt_collision)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   int r_lo, r_hi, r_sthold;
   bit r_rsp, r_evt, r_rd, r_rdy_busy, r_unstable, r_down_hi, r_up_hi;
   bit r_end_scl, r_end_sda, r_timeout, r_sda_at_rel;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [2:0] code, input logic wd, input logic oth, input int stretch);
      bit seen_rel, prev_sda, bus_scl;
      int hold_left;
      @(negedge clk);
      cmd_code = code; cmd_wdata = wd; cmd_valid = 1'b1; other_sda_low = oth;
      prev_sda = sda_oe;
      hold_left = stretch;
      slave_scl_hold = (stretch > 0);
      r_lo = 0; r_hi = 0; r_sthold = 0; r_rsp = 0; r_evt = 0; r_rd = 0;
      r_rdy_busy = 0; r_unstable = 0; r_down_hi = 0; r_up_hi = 0;
      r_timeout = 1; r_sda_at_rel = 0; seen_rel = 0;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int i = 0; i < 2000; i++) begin
         if (slave_scl_hold && !scl_oe) begin
            hold_left--;
            if (hold_left <= 0) slave_scl_hold = 1'b0;
         end
         bus_scl = !(scl_oe || slave_scl_hold);
         if (!scl_oe && !seen_rel && code != 3'd0) begin
            seen_rel = 1; r_sda_at_rel = sda_oe;
         end
         if (scl_oe && !seen_rel) r_lo++;
         if (!scl_oe && bus_scl && seen_rel) r_hi++;
         if (sda_oe && !scl_oe) r_sthold++;
         if (seen_rel && !scl_oe && sda_oe != r_sda_at_rel) r_unstable = 1;
         if (!prev_sda && sda_oe && bus_scl) r_down_hi = 1;
         if (prev_sda && !sda_oe && bus_scl) r_up_hi = 1;
         prev_sda = sda_oe;
         if (rsp_valid || evt_collision) begin
            r_rsp = rsp_valid; r_evt = evt_collision; r_rd = rsp_rdata;
            r_end_scl = scl_oe; r_end_sda = sda_oe; r_timeout = 0;
            break;
         end
         if (cmd_ready) r_rdy_busy = 1;
         @(negedge clk);
      end
      slave_scl_hold = 1'b0;
      if (!evt_collision) other_sda_low = 1'b0;
      chk(!r_timeout, "R2 op completes", int'(r_timeout), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cmd_ready == 1'b1, "R1 cmd_ready", int'(cmd_ready), 1);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released", int'({scl_oe, sda_oe}), 0);
      chk(rsp_valid == 1'b0 && evt_collision == 1'b0, "R1 rsp/evt", int'({rsp_valid, evt_collision}), 0);

      // R6 Start from idle
      run_op(3'd0, 1'b0, 1'b0, 0);
      chk(r_rsp, "R2 start response", int'(r_rsp), 1);
      chk(r_down_hi, "R6 SDA falls while SCL high", int'(r_down_hi), 1);
      chk(r_sthold == LO_EXP, "R6 start hold", r_sthold, LO_EXP);
      chk(r_end_scl && r_end_sda, "R6 end both driven", int'({r_end_scl, r_end_sda}), 3);

      // table of data bits
      for (int v = 0; v < NV; v++) begin
         logic [10:0] e;
         e = VEC[v];
         run_op(e[10:8], e[7], e[6], int'(e[5:2]));
         chk(r_evt == e[0], "R9 no collision on clean bit", int'(r_evt), int'(e[0]));
         chk(r_rsp, "R2 bit response", int'(r_rsp), 1);
         chk(!r_rdy_busy, "R2 ready low while busy", int'(r_rdy_busy), 0);
         chk(r_lo == LO_EXP, "R3 low phase", r_lo, LO_EXP);
         if (e[5:2] != 4'd0)
            chk(r_hi == HI_EXP, "R5 stretched high phase", r_hi, HI_EXP);
         else
            chk(r_hi == HI_EXP, "R4 high phase", r_hi, HI_EXP);
         chk(!r_unstable && !r_down_hi && !r_up_hi, "R9 SDA stable while SCL high",
             int'({r_unstable, r_down_hi, r_up_hi}), 0);
         chk(r_end_scl == 1'b1, "R9 ends with SCL low", int'(r_end_scl), 1);
         if (e[10:8] == 3'd3)
            chk(r_sda_at_rel == !e[7], "R9 sda_oe is inverse data", int'(r_sda_at_rel), int'(!e[7]));
         else
            chk(r_rd == e[1] && r_sda_at_rel == 1'b0, "R10 read data", int'(r_rd), int'(e[1]));
      end

      // R8 repeated Start
      run_op(3'd1, 1'b0, 1'b0, 0);
      chk(r_rsp, "R2 restart response", int'(r_rsp), 1);
      chk(r_lo == LO_EXP, "R3 restart low phase", r_lo, LO_EXP);
      chk(r_sda_at_rel == 1'b0, "R8 SDA released before SCL", int'(r_sda_at_rel), 0);
      chk(r_down_hi, "R8 SDA falls while SCL high", int'(r_down_hi), 1);
      chk(r_sthold == LO_EXP, "R8 start hold", r_sthold, LO_EXP);
      chk(r_end_scl && r_end_sda, "R8 end both driven", int'({r_end_scl, r_end_sda}), 3);

      run_op(3'd3, 1'b0, 1'b0, 0);
      chk(r_rsp && r_hi == HI_EXP, "R4 bit after restart", r_hi, HI_EXP);

      // R7 Stop
      run_op(3'd2, 1'b0, 1'b0, 0);
      chk(r_lo == LO_EXP, "R3 stop low phase", r_lo, LO_EXP);
      chk(r_sda_at_rel == 1'b1, "R7 SDA low when SCL released", int'(r_sda_at_rel), 1);
      chk(r_up_hi, "R7 SDA rises while SCL high", int'(r_up_hi), 1);
      chk(!r_end_scl && !r_end_sda, "R7 both released", int'({r_end_scl, r_end_sda}), 0);

      // R13 reserved codes ignored
      for (int c = 5; c < 8; c++) begin
         bit moved;
         moved = 0;
         @(negedge clk);
         cmd_code = 3'(c); cmd_valid = 1'b1;
         @(negedge clk);
         cmd_valid = 1'b0;
         for (int i = 0; i < 20; i++) begin
            if (scl_oe || sda_oe || rsp_valid || !cmd_ready) moved = 1;
            @(negedge clk);
         end
         chk(!moved, "R13 reserved code ignored", int'(moved), 0);
      end

      // R11 second master wins mid-byte
      run_op(3'd0, 1'b0, 1'b0, 0);
      run_op(3'd3, 1'b1, 1'b0, 0);
      run_op(3'd3, 1'b0, 1'b0, 0);
      chk(r_rsp && !r_evt, "R9 bits before loss", int'(r_evt), 0);
      run_op(3'd3, 1'b1, 1'b1, 0);
      chk(r_evt == 1'b1, "R11 event flag set", int'(r_evt), 1);
      chk(r_rsp == 1'b0, "R11 no response", int'(r_rsp), 0);
      chk(!r_end_scl && !r_end_sda, "R11 lines released", int'({r_end_scl, r_end_sda}), 0);
      chk(cmd_ready == 1'b0, "R12 ready low with flag", int'(cmd_ready), 0);
      other_sda_low = 1'b0;

      // R12 commands blocked while flagged
      begin
         bit moved;
         moved = 0;
         @(negedge clk);
         cmd_code = 3'd0; cmd_valid = 1'b1;
         for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (scl_oe || sda_oe || rsp_valid || !evt_collision) moved = 1;
         end
         cmd_valid = 1'b0;
         chk(!moved, "R12 command ignored while flagged", int'(moved), 0);
      end
      @(negedge clk);
      evt_clear = 1'b1;
      @(negedge clk);
      evt_clear = 1'b0;
      chk(evt_collision == 1'b0, "R12 flag cleared", int'(evt_collision), 0);
      chk(cmd_ready == 1'b1, "R12 ready back", int'(cmd_ready), 1);
      run_op(3'd0, 1'b0, 1'b0, 0);
      chk(r_rsp, "R12 start works after clear", int'(r_rsp), 1);
      run_op(3'd2, 1'b0, 1'b0, 0);
      chk(r_rsp && !r_end_scl && !r_end_sda, "R7 stop after clear", int'(r_rsp), 1);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule